// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block is the clocked control logic behind one phase of a synchronous buck converter. External comparators have already turned the analogue PWM command and the mode pin into three-level codes. The block turns those codes, a negative-inductor-current flag, two gate-discharged flags and a supply-good flag into the enables for the high-side and low-side gate drivers. It keeps the two switches from conducting together. It inserts an adaptive dead time, filters mid-level PWM excursions with a hold-off window, and supports diode emulation at light load and forced continuous conduction. It also provides a float-controlled standby with an exit latency and an undervoltage clamp.

All timing is expressed in clock cycles through parameters: the tri-state hold-off window, the fixed delay added after the opposite gate reports discharged, and the standby exit latency. A 3-bit state code is brought out so that the sequencing can be observed from outside.

Top module: `gate_seq_top`

## Requirements
- R1: Three-level inputs use 00 = low, 01 = high, 10 = mid/float, and 11 is treated as mid/float. The state output codes are 0 off, 1 high-side on, 2 low-side on, 3 dead-time wait, 4 tri-state off, 5 shutdown, 6 exit wait. After reset both gate enables are 0 and the state is 0.
- R2: With a valid mode, a PWM high leads through a dead-time wait to high-side on (state 1). A PWM low leads the same way to low-side on (state 2). The gate being left drops in the cycle that the wait is entered.
- R3: In dead-time wait, the target gate turns on only after the opposite gate's discharged flag has been 1 for DT_CYC consecutive cycles. If the flag drops, the count restarts. Both enables are never 1 together.
- R4: PWM at mid level for HOLD_CYC consecutive cycles moves the state to tri-state off (4) with both gates off. A mid-level excursion of fewer cycles leaves the state and the gates unchanged.
- R5: With mode low (diode emulation), PWM low and state 2, a 1 on the negative-current flag drops the low-side enable in the same cycle and moves the state to 0. The low side then stays off until PWM has been high again.
- R6: With mode high (forced continuous), the negative-current flag is ignored. A switch to mode high while the low side is blanked takes effect at once and restarts the low side through a dead-time wait.
- R7: A floating mode pin forces both enables to 0 in the same cycle and the state to 0 on the next edge. If PWM is also held mid for HOLD_CYC cycles, the state becomes shutdown (5).
- R8: From shutdown, any change away from float/mid moves the state to exit wait (6). The state stays there for EXIT_CYC cycles with both gates off, and then goes to 0.
- R9: A 0 on supply-good forces both enables to 0 in the same cycle and the state to 0 on the next edge, whatever the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_lvl | input | 2 | Quantized PWM command (R1 encoding) |
| mode_lvl | input | 2 | Quantized mode pin: low = diode emulation, high = continuous, float = off/standby |
| il_neg | input | 1 | Inductor current at or below zero |
| hs_low | input | 1 | High-side gate reported discharged |
| ls_low | input | 1 | Low-side gate reported discharged |
| supply_ok | input | 1 | Control supply above lockout threshold |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| seq_state | output | 3 | Sequencer state code (R1) |

## Verification
The assertions assume that every input is already synchronous to the clock and holds steady between edges. They also assume that the discharged flags reflect the gate enables, so a gate reported discharged has really been released. The stimulus changes inputs only on the falling clock edge, one step at a time, and keeps the discharged flags at 1 except during deliberate dead-time stalls. Mid-level excursions, negative-current pulses and supply drops are placed both inside and outside the sequencing windows, so each window boundary is hit from both sides.

// File: rtl/gds_pkg.sv
package gds_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_HS   = 3'd1,
    ST_LS   = 3'd2,
    ST_DT   = 3'd3,
    ST_TRI  = 3'd4,
    ST_SHDN = 3'd5,
    ST_EXIT = 3'd6
  } seq_st_e;

  typedef enum logic [1:0] {
    W_STAY = 2'd0,
    W_OFF  = 2'd1,
    W_HS   = 2'd2,
    W_LS   = 2'd3
  } want_e;

  localparam logic [1:0] LVL_LO = 2'b00;
  localparam logic [1:0] LVL_HI = 2'b01;

endpackage

// File: rtl/gds_tri_filter.sv
module gds_tri_filter #(
  parameter int HOLD_CYC = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mid_in,
  output logic tri_off
);
  localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [CW-1:0] SAT = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tri_off = mid_in & (cnt_q == SAT);
  assign cnt_en  = ~mid_in | (cnt_q != SAT);

  always_comb begin
    cnt_d = cnt_q;
    if (!mid_in)          cnt_d = '0;
    else if (cnt_q < SAT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TRI_NEEDS_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $past(mid_in)); // R4
endmodule

// File: rtl/gds_wait_timer.sv
module gds_wait_timer #(
  parameter int LIM = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int CW = (LIM < 2) ? 1 : $clog2(LIM);
  localparam logic [CW-1:0] LAST = CW'(LIM - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = run & (cnt_q == LAST);
  assign cnt_en = clr | (run & ~done);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                cnt_d = '0;
    else if (run && !done)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R3
endmodule

// File: rtl/gate_seq_top.sv
module gate_seq_top
  import gds_pkg::*;
#(
  parameter int HOLD_CYC = 38,
  parameter int DT_CYC   = 5,
  parameter int EXIT_CYC = 1250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_lvl,
  input  logic [1:0] mode_lvl,
  input  logic       il_neg,
  input  logic       hs_low,
  input  logic       ls_low,
  input  logic       supply_ok,
  output logic       hs_en,
  output logic       ls_en,
  output logic [2:0] seq_state
);
  seq_st_e st_q, st_d;
  logic    tgt_hs_q, tgt_hs_d;
  logic    zc_q, zc_d;
  want_e   want;

  logic pwm_hi, pwm_lo, pwm_mid;
  logic mode_de, mode_ccm, mode_flt;
  logic tri_off;
  logic opp_low;
  logic dt_clr, dt_run, dt_done;
  logic ex_clr, ex_run, ex_done;

  assign pwm_hi   = (pwm_lvl == LVL_HI);
  assign pwm_lo   = (pwm_lvl == LVL_LO);
  assign pwm_mid  = ~pwm_hi & ~pwm_lo;
  assign mode_de  = (mode_lvl == LVL_LO);
  assign mode_ccm = (mode_lvl == LVL_HI);
  assign mode_flt = ~mode_de & ~mode_ccm;

  gds_tri_filter #(.HOLD_CYC(HOLD_CYC)) u_tri (
    .clk(clk), .rst_n(rst_n), .mid_in(pwm_mid), .tri_off(tri_off)
  );

  assign opp_low = tgt_hs_q ? ls_low : hs_low;
  assign dt_run  = (st_q == ST_DT) & opp_low;

  gds_wait_timer #(.LIM(DT_CYC)) u_dt (
    .clk(clk), .rst_n(rst_n), .clr(dt_clr), .run(dt_run), .done(dt_done)
  );

  assign ex_run = (st_q == ST_EXIT);
  assign ex_clr = ~ex_run;

  gds_wait_timer #(.LIM(EXIT_CYC)) u_exit (
    .clk(clk), .rst_n(rst_n), .clr(ex_clr), .run(ex_run), .done(ex_done)
  );

  // requested switch position for this cycle
  always_comb begin
    want = W_STAY;
    if (pwm_hi) begin
      want = W_HS;
    end else if (pwm_lo) begin
      if (mode_de && (zc_q || (st_q == ST_LS && il_neg))) want = W_OFF;
      else                                                  want = W_LS;
    end else begin
      if (st_q == ST_LS && mode_de && il_neg) want = W_OFF;
      else if (st_q == ST_DT)                 want = tgt_hs_q ? W_HS : W_LS;
    end
  end

  // next state
  always_comb begin
    st_d     = st_q;
    tgt_hs_d = tgt_hs_q;
    dt_clr   = (st_q != ST_DT) | ~opp_low;
    if (!supply_ok) begin
      st_d = ST_OFF;
    end else if (st_q == ST_SHDN) begin
      if (!(mode_flt && pwm_mid)) st_d = ST_EXIT;
    end else if (st_q == ST_EXIT) begin
      if (ex_done) st_d = ST_OFF;
    end else if (mode_flt) begin
      st_d = tri_off ? ST_SHDN : ST_OFF;
    end else if (tri_off) begin
      st_d = ST_TRI;
    end else begin
      unique case (want)
        W_OFF: st_d = ST_OFF;
        W_HS: begin
          if (st_q == ST_DT && tgt_hs_q) begin
            if (dt_done) st_d = ST_HS;
          end else if (st_q != ST_HS) begin
            st_d     = ST_DT;
            tgt_hs_d = 1'b1;
            dt_clr   = 1'b1;
          end
        end
        W_LS: begin
          if (st_q == ST_DT && !tgt_hs_q) begin
            if (dt_done) st_d = ST_LS;
          end else if (st_q != ST_LS) begin
            st_d     = ST_DT;
            tgt_hs_d = 1'b0;
            dt_clr   = 1'b1;
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_comb begin
    zc_d = zc_q;
    if (pwm_hi)                                       zc_d = 1'b0;
    else if (st_q == ST_LS && mode_de && il_neg)      zc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_OFF;
      tgt_hs_q <= 1'b0;
      zc_q     <= 1'b0;
    end else begin
      st_q     <= st_d;
      tgt_hs_q <= tgt_hs_d;
      zc_q     <= zc_d;
    end
  end

  // gate enables are qualified combinationally so clamps act without a clock
  assign hs_en = (st_q == ST_HS) & supply_ok & ~mode_flt;
  assign ls_en = (st_q == ST_LS) & supply_ok & ~mode_flt & ~(mode_de & il_neg);
  assign seq_state = st_q;

  AST_HS_AFTER_LS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HS && $past(st_q) != ST_HS) |-> $past(ls_low)); // R3
  AST_LS_AFTER_HS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LS && $past(st_q) != ST_LS) |-> $past(hs_low)); // R3
  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en)); // R3
  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (st_q == ST_OFF)); // R9
  AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_flt && supply_ok && st_q != ST_SHDN && st_q != ST_EXIT)
      |=> (st_q == ST_OFF || st_q == ST_SHDN)); // R7
  AST_ZC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LS && mode_de && pwm_lo && il_neg && supply_ok) |=> (st_q == ST_OFF)); // R5
  AST_EXIT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXIT && supply_ok) |=> (st_q == ST_EXIT || st_q == ST_OFF)); // R8
endmodule

// File: tb/gate_seq_top_tb.sv
`timescale 1ns/1ps
module gate_seq_top_tb;
  localparam int HOLD = 6;
  localparam int DT   = 3;
  localparam int EXC  = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pwm_lvl, mode_lvl;
  logic       il_neg, hs_low, ls_low, supply_ok;
  logic       hs_en, ls_en;
  logic [2:0] seq_state;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gate_seq_top #(.HOLD_CYC(HOLD), .DT_CYC(DT), .EXIT_CYC(EXC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .mode_lvl(mode_lvl),
    .il_neg(il_neg), .hs_low(hs_low), .ls_low(ls_low), .supply_ok(supply_ok),
    .hs_en(hs_en), .ls_en(ls_en), .seq_state(seq_state)
  );

  // behavioural reference: 0 off,1 hs,2 ls,3 wait,4 tri,5 shdn,6 exit
  int m_st, m_mid, m_dt, m_ex;
  bit m_tgt_hs, m_zc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_mid = 0; m_dt = 0; m_ex = 0; m_tgt_hs = 0; m_zc = 0;
    end else begin
      bit hi, lo, mid, de, flt, tri_now, opp;
      int want, nst, ndt, nex;
      bit ntgt;
      hi  = (pwm_lvl == 2'b01);
      lo  = (pwm_lvl == 2'b00);
      mid = !hi && !lo;
      de  = (mode_lvl == 2'b00);
      flt = (mode_lvl[1] == 1'b1);
      tri_now = mid && (m_mid >= HOLD - 1);
      opp = m_tgt_hs ? ls_low : hs_low;
      // want: 0 stay, 1 off, 2 high side, 3 low side
      want = 0;
      if (hi) want = 2;
      else if (lo) want = (de && (m_zc || (m_st == 2 && il_neg))) ? 1 : 3;
      else if (m_st == 2 && de && il_neg) want = 1;
      else if (m_st == 3) want = m_tgt_hs ? 2 : 3;
      nst = m_st; ntgt = m_tgt_hs;
      ndt = (m_st == 3 && opp) ? ((m_dt == DT - 1) ? m_dt : m_dt + 1) : 0;
      nex = (m_st == 6) ? ((m_ex == EXC - 1) ? m_ex : m_ex + 1) : 0;
      if (!supply_ok) nst = 0;
      else if (m_st == 5) begin
        if (!(flt && mid)) nst = 6;
      end else if (m_st == 6) begin
        if (m_ex == EXC - 1) nst = 0;
      end else if (flt) nst = tri_now ? 5 : 0;
      else if (tri_now) nst = 4;
      else if (want == 1) nst = 0;
      else if (want == 2 || want == 3) begin
        bit to_hs;
        to_hs = (want == 2);
        if (m_st == 3 && m_tgt_hs == to_hs) begin
          if (opp && m_dt == DT - 1) nst = to_hs ? 1 : 2;
        end else if (m_st != (to_hs ? 1 : 2)) begin
          nst = 3; ntgt = to_hs; ndt = 0;
        end
      end
      if (hi) m_zc = 0;
      else if (m_st == 2 && de && il_neg) m_zc = 1;
      m_mid = mid ? ((m_mid + 1 > HOLD - 1) ? HOLD - 1 : m_mid + 1) : 0;
      m_st = nst; m_tgt_hs = ntgt; m_dt = ndt; m_ex = nex;
    end
  end

  task automatic compare(input string tag);
    bit flt, de, ehs, els;
    flt = (mode_lvl[1] == 1'b1);
    de  = (mode_lvl == 2'b00);
    ehs = (m_st == 1) && supply_ok && !flt;
    els = (m_st == 2) && supply_ok && !flt && !(de && il_neg);
    n_chk++;
    if (seq_state !== 3'(m_st) || hs_en !== ehs || ls_en !== els) begin
      n_err++;
      $display("FAIL %s: state/hs/ls actual %0d/%0b/%0b expected %0d/%0b/%0b",
               tag, seq_state, hs_en, ls_en, m_st, ehs, els);
    end
  endtask

  task automatic cyc(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare(tag);
    end
  endtask

  task automatic expect_st(input int s, input bit hs, input bit ls, input string tag);
    n_chk++;
    if (seq_state !== 3'(s) || hs_en !== hs || ls_en !== ls) begin
      n_err++;
      $display("FAIL %s: directed state/hs/ls actual %0d/%0b/%0b expected %0d/%0b/%0b",
               tag, seq_state, hs_en, ls_en, s, hs, ls);
    end
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pwm_lvl = 2'b10; mode_lvl = 2'b01; il_neg = 0;
    hs_low = 1; ls_low = 1; supply_ok = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_st(0, 0, 0, "R1 reset");
    compare("R1");
    // short mid while idle: nothing happens
    cyc(HOLD - 1, "R4");
    expect_st(0, 0, 0, "R4 short mid idle");
    // PWM high -> dead time -> high side
    pwm_lvl = 2'b01;
    cyc(1, "R2");
    expect_st(3, 0, 0, "R2 enter wait");
    cyc(DT, "R2");
    expect_st(1, 1, 0, "R2 high side");
    // PWM low with high gate still charged: wait stalls
    pwm_lvl = 2'b00; hs_low = 0;
    cyc(5, "R3");
    expect_st(3, 0, 0, "R3 stall");
    hs_low = 1;
    cyc(DT, "R3");
    expect_st(2, 0, 1, "R2 low side");
    // short mid excursion keeps low side
    pwm_lvl = 2'b10;
    cyc(HOLD - 1, "R4");
    expect_st(2, 0, 1, "R4 short excursion");
    pwm_lvl = 2'b00; cyc(2, "R4");
    // full hold-off
    pwm_lvl = 2'b10;
    cyc(HOLD, "R4");
    expect_st(4, 0, 0, "R4 tri off");
    pwm_lvl = 2'b00;
    cyc(1 + DT, "R2");
    expect_st(2, 0, 1, "R2 from tri");
    // diode emulation
    mode_lvl = 2'b00; cyc(2, "R5");
    il_neg = 1; #0.5;
    compare("R5 immediate");
    cyc(1, "R5");
    expect_st(0, 0, 0, "R5 zero cross");
    il_neg = 0; cyc(3, "R5");
    expect_st(0, 0, 0, "R5 blanked");
    // switch to continuous
    mode_lvl = 2'b01;
    cyc(1 + DT, "R6");
    expect_st(2, 0, 1, "R6 resume");
    il_neg = 1; cyc(3, "R6");
    expect_st(2, 0, 1, "R6 negative ignored");
    il_neg = 0;
    // dead-time restart on flag drop
    pwm_lvl = 2'b01;
    cyc(1 + DT - 1, "R3");
    ls_low = 0; cyc(2, "R3");
    ls_low = 1; cyc(DT - 1, "R3");
    expect_st(3, 0, 0, "R3 restarted");
    cyc(1, "R3");
    expect_st(1, 1, 0, "R3 after restart");
    // blank cleared by high period
    pwm_lvl = 2'b00; mode_lvl = 2'b00;
    cyc(1 + DT, "R5");
    expect_st(2, 0, 1, "R5 new low period");
    // undervoltage
    pwm_lvl = 2'b01; cyc(1 + DT, "R9");
    supply_ok = 0; #0.5;
    expect_st(1, 0, 0, "R9 immediate clamp");
    cyc(3, "R9");
    expect_st(0, 0, 0, "R9 held off");
    supply_ok = 1;
    cyc(1 + DT, "R9");
    expect_st(1, 1, 0, "R9 recovery");
    // float mode and shutdown, invalid code 11 as mid
    mode_lvl = 2'b10; #0.5;
    expect_st(1, 0, 0, "R7 immediate");
    pwm_lvl = 2'b11;
    cyc(1, "R7");
    expect_st(0, 0, 0, "R7 off");
    cyc(HOLD - 1, "R7");
    expect_st(5, 0, 0, "R1 R7 shutdown");
    cyc(3, "R7");
    // exit latency
    mode_lvl = 2'b01; pwm_lvl = 2'b00;
    cyc(1, "R8");
    expect_st(6, 0, 0, "R8 exit wait");
    cyc(EXC - 1, "R8");
    expect_st(6, 0, 0, "R8 still waiting");
    cyc(1, "R8");
    expect_st(0, 0, 0, "R8 done");
    cyc(1 + DT, "R8");
    expect_st(2, 0, 1, "R8 resumed");
    // mixed stimulus against the reference
    for (int k = 0; k < 600; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 25)      pwm_lvl = 2'b01;
      else if (r < 50) pwm_lvl = 2'b00;
      else if (r < 56) pwm_lvl = 2'b10;
      if ($urandom_range(0, 49) == 0) mode_lvl = 2'($urandom_range(0, 3));
      il_neg    = ($urandom_range(0, 9) == 0);
      hs_low    = ($urandom_range(0, 7) != 0) || !hs_en;
      ls_low    = ($urandom_range(0, 7) != 0) || !ls_en;
      supply_ok = ($urandom_range(0, 99) != 0);
      cyc(1, "R2 R3 R5 R6 mixed");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule